// File: doc/BRIEF.md
# Interrupt-Acknowledge Address Trace Register

This debug block sits beside a soft CPU on its memory bus. Each time the CPU runs an interrupt-acknowledge cycle, the block stores the program address present on that cycle. That is the address of the instruction the interrupt broke into. A later acknowledge overwrites the stored value. Software reads the stored address back as a short run of bytes at a fixed location in the memory map. A fault that correlates with interrupts can then be traced to one instruction without spare pins or external probes.

Two small debug aids come with it. The first is an LED that follows bit 0 of any byte the CPU writes to one chosen address. The second is a switch input. It passes through a synchroniser and then gates the external interrupt request before the request reaches the CPU, so interrupts can be turned off from outside to test whether a fault depends on them. In the intended system the only interrupt source is a periodic 20 ms frame-sync pulse.

Top module: `irq_ack_trace`

## Requirements
- R1: After reset the stored address, the LED, the read data, the read-hit flag and the gated interrupt output are all zero.
- R2: A clock edge with `cpu_iack` high stores `cpu_pc`. Every later acknowledge replaces the value. Without an acknowledge the value holds, whatever `cpu_pc` does.
- R3: A read at `CAP_BASE + k` returns byte k of the stored address one cycle later, with `bus_rd_hit` high. Byte 0 is bits 7:0, byte 1 is bits 15:8, and byte 2 is bits 19:16 with zeros in its upper four bits.
- R4: A read outside the capture window, or a cycle with no read, gives `bus_rdata` = 0 and `bus_rd_hit` = 0 on the next cycle.
- R5: A write to `LED_ADDR` sets `dbg_led` to bit 0 of the written byte on the next cycle. The LED holds through idle cycles and through writes to any other address.
- R6: Writes to the capture window leave the stored address unchanged.
- R7: While the synchronised switch is clear, `cpu_irq` equals `irq_req` delayed by one cycle. While it is set, `cpu_irq` stays low whatever `irq_req` does.
- R8: With `SYNC_STAGES` = 2, a change of `irq_mask_sw` first affects `cpu_irq` on the third clock edge after the change.
- R9: A read of the window in the same cycle as an acknowledge returns the value stored before that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data, zero when not selected |
| bus_rd_hit | output | 1 | Registered flag: the previous read hit the capture window |
| cpu_pc | input | PC_W | Current program address |
| cpu_iack | input | 1 | Interrupt-acknowledge strobe |
| irq_req | input | 1 | External interrupt request |
| irq_mask_sw | input | 1 | Asynchronous mask switch, high blocks interrupts |
| cpu_irq | output | 1 | Gated, registered interrupt request to the CPU |
| dbg_led | output | 1 | Debug LED |

## Verification
The bench keeps the default sizes: a 16-bit bus, a 20-bit program address, and a two-stage synchroniser. The capture window is placed at 0x0F00 and the LED at 0x0F10. With a 20-bit address, a walking-one sweep reaches every bit of the stored value. It also exercises the zero-filled top nibble of the third byte. A 48-address read sweep covers the window, both of its edges, and the LED address. Because the synchroniser is only two stages deep, the mask latency of R8 can be checked edge by edge.

// File: rtl/irq_ack_trace_pkg.sv
package irq_ack_trace_pkg;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/iat_sync.sv
module iat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/iat_irq_gate.sv
module iat_irq_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  logic mask_async,
  output logic mask_sync,
  output logic req_out
);
  iat_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mask_async),
    .q   (mask_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) req_out <= 1'b0;
    else     req_out <= req_in & ~mask_sync;
  end
endmodule

// File: rtl/iat_capture.sv
module iat_capture #(
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack,
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (ack) value <= pc;
  end
endmodule

// File: rtl/iat_busport.sv
module iat_busport
  import irq_ack_trace_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                PC_W     = 20,
  parameter logic [ADDR_W-1:0] CAP_BASE = 16'h0F00,
  parameter logic [ADDR_W-1:0] LED_ADDR = 16'h0F10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic [PC_W-1:0]   cap,
  output logic [BYTE_W-1:0] rdata,
  output logic              rd_hit,
  output logic              led
);
  localparam int NB  = bytes_for(PC_W);
  localparam int PAD = NB * BYTE_W;

  logic [ADDR_W-1:0] offset;
  logic              in_win;
  logic [PAD-1:0]    padded;
  logic [BYTE_W-1:0] sel_byte;

  assign offset = addr - CAP_BASE;
  assign in_win = offset < ADDR_W'(NB);

  always_comb begin
    padded = '0;
    padded[PC_W-1:0] = cap;
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (offset == ADDR_W'(i)) sel_byte = padded[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_hit <= 1'b0;
    end else if (rd && in_win) begin
      rdata  <= sel_byte;
      rd_hit <= 1'b1;
    end else begin
      rdata  <= '0;
      rd_hit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       led <= 1'b0;
    else if (wr && addr == LED_ADDR) led <= wdata[0];
  end
endmodule

// File: rtl/irq_ack_trace.sv
module irq_ack_trace #(
  parameter int                ADDR_W      = 16,
  parameter int                PC_W        = 20,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CAP_BASE    = 16'h0F00,
  parameter logic [ADDR_W-1:0] LED_ADDR    = 16'h0F10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              bus_rd_hit,
  input  logic [PC_W-1:0]   cpu_pc,
  input  logic              cpu_iack,
  input  logic              irq_req,
  input  logic              irq_mask_sw,
  output logic              cpu_irq,
  output logic              dbg_led
);
  logic [PC_W-1:0] cap_q;
  logic            mask_s;

  iat_irq_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .req_in     (irq_req),
    .mask_async (irq_mask_sw),
    .mask_sync  (mask_s),
    .req_out    (cpu_irq)
  );

  iat_capture #(.PC_W(PC_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .ack   (cpu_iack),
    .pc    (cpu_pc),
    .value (cap_q)
  );

  iat_busport #(
    .ADDR_W   (ADDR_W),
    .PC_W     (PC_W),
    .CAP_BASE (CAP_BASE),
    .LED_ADDR (LED_ADDR)
  ) u_bus (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .cap    (cap_q),
    .rdata  (bus_rdata),
    .rd_hit (bus_rd_hit),
    .led    (dbg_led)
  );
endmodule

// File: rtl/irq_ack_trace_chk.sv
module irq_ack_trace_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                PC_W     = 20,
  parameter logic [ADDR_W-1:0] CAP_BASE = 16'h0F00,
  parameter logic [ADDR_W-1:0] LED_ADDR = 16'h0F10
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              bus_rd_hit,
  input logic [PC_W-1:0]   cpu_pc,
  input logic              cpu_iack,
  input logic              irq_req,
  input logic              cpu_irq,
  input logic              dbg_led,
  input logic [PC_W-1:0]   cap_q,
  input logic              mask_s
);
  localparam int NB = (PC_W + 7) / 8;
  logic win;
  assign win = (bus_addr >= CAP_BASE) && ((bus_addr - CAP_BASE) < ADDR_W'(NB));

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    cpu_iack |=> cap_q == $past(cpu_pc)); // R2
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cpu_iack |=> $stable(cap_q)); // R2
  AST_READ_HIT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win) |=> bus_rd_hit); // R3
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && win) |=> (bus_rdata == 8'h00) && !bus_rd_hit); // R4
  AST_LED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == LED_ADDR) |=> dbg_led == $past(bus_wdata[0])); // R5
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == LED_ADDR) |=> $stable(dbg_led)); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(irq_req)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    mask_s |=> !cpu_irq); // R7
endmodule

bind irq_ack_trace irq_ack_trace_chk #(
  .ADDR_W   (ADDR_W),
  .PC_W     (PC_W),
  .CAP_BASE (CAP_BASE),
  .LED_ADDR (LED_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_rd_hit (bus_rd_hit),
  .cpu_pc     (cpu_pc),
  .cpu_iack   (cpu_iack),
  .irq_req    (irq_req),
  .cpu_irq    (cpu_irq),
  .dbg_led    (dbg_led),
  .cap_q      (cap_q),
  .mask_s     (mask_s)
);

// File: tb/tb_irq_ack_trace.sv
module tb_irq_ack_trace;
  localparam logic [15:0] BASE = 16'h0F00;
  localparam logic [15:0] LEDA = 16'h0F10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rd_hit;
  logic [19:0] cpu_pc = '0;
  logic        cpu_iack = 1'b0;
  logic        irq_req = 1'b0;
  logic        irq_mask_sw = 1'b0;
  logic        cpu_irq;
  logic        dbg_led;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_ack_trace dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rd_hit(bus_rd_hit), .cpu_pc(cpu_pc), .cpu_iack(cpu_iack),
    .irq_req(irq_req), .irq_mask_sw(irq_mask_sw), .cpu_irq(cpu_irq),
    .dbg_led(dbg_led)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ack(input logic [19:0] v);
    cpu_pc = v; cpu_iack = 1'b1;
    tick();
    cpu_iack = 1'b0;
  endtask

  task automatic rd_byte(input logic [15:0] a, output int d, output int h);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata; h = bus_rd_hit;
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic expect_cap(input string req, input int v);
    int d, h;
    for (int k = 0; k < 3; k++) begin
      rd_byte(BASE + 16'(k), d, h);
      check(req, d, (k == 2) ? ((v >> 16) & 'hF) : ((v >> (8 * k)) & 'hFF));
      check(req, h, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int d, h;
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 led", dbg_led, 0);
    check("R1 rdata", bus_rdata, 0);
    check("R1 hit", bus_rd_hit, 0);
    check("R1 irq", cpu_irq, 0);
    expect_cap("R1 cap", 0);

    // R2 R3 walking one and patterns
    for (int b = 0; b < 20; b++) begin
      ack(20'(1) << b);
      expect_cap("R2/R3 walk", 1 << b);
    end
    ack(20'hFFFFF); expect_cap("R3 all ones", 'hFFFFF);
    ack(20'hABCDE); expect_cap("R2 overwrite", 'hABCDE);

    // R2 hold while pc moves
    ack(20'h12345);
    for (int i = 0; i < 6; i++) begin cpu_pc = 20'(i * 'h1111 + 7); tick(); end
    expect_cap("R2 hold", 'h12345);

    // R3 R4 address sweep
    for (int a = 'h0EF0; a < 'h0F20; a++) begin
      int in;
      rd_byte(16'(a), d, h);
      in = (a >= 'h0F00 && a < 'h0F03);
      check(in ? "R3 sweep" : "R4 sweep", h, in);
      check(in ? "R3 sweep" : "R4 sweep", d,
            !in ? 0 : (a == 'h0F00) ? 'h45 : (a == 'h0F01) ? 'h23 : 'h1);
    end
    bus_addr = BASE; tick();
    check("R4 no strobe data", bus_rdata, 0);
    check("R4 no strobe hit", bus_rd_hit, 0);

    // R6 writes to window ignored
    for (int k = 0; k < 3; k++) wr_byte(BASE + 16'(k), 8'hFF);
    expect_cap("R6 write ignored", 'h12345);

    // R5 LED
    wr_byte(LEDA, 8'h01); check("R5 led set", dbg_led, 1);
    wr_byte(LEDA, 8'hFE); check("R5 led bit0 clear", dbg_led, 0);
    wr_byte(LEDA, 8'h03); check("R5 led set again", dbg_led, 1);
    wr_byte(LEDA + 16'd1, 8'h00); check("R5 other addr", dbg_led, 1);
    wr_byte(BASE, 8'h00); check("R5 window addr", dbg_led, 1);
    repeat (4) tick(); check("R5 idle hold", dbg_led, 1);

    // R9 read with concurrent acknowledge
    bus_addr = BASE; bus_rd = 1'b1; cpu_pc = 20'h54321; cpu_iack = 1'b1;
    tick();
    bus_rd = 1'b0; cpu_iack = 1'b0;
    check("R9 old byte", bus_rdata, 'h45);
    expect_cap("R9 new value", 'h54321);

    // R7 pass-through
    irq_mask_sw = 1'b0; repeat (3) tick();
    for (int i = 0; i < 4; i++) begin
      irq_req = i[0]; tick();
      check("R7 follow", cpu_irq, i[0]);
    end
    irq_mask_sw = 1'b1; repeat (3) tick();
    for (int i = 0; i < 4; i++) begin
      irq_req = i[0]; tick();
      check("R7 masked", cpu_irq, 0);
    end

    // R8 mask latency
    irq_mask_sw = 1'b0; irq_req = 1'b1; repeat (4) tick();
    check("R8 pre", cpu_irq, 1);
    irq_mask_sw = 1'b1;
    tick(); check("R8 edge1", cpu_irq, 1);
    tick(); check("R8 edge2", cpu_irq, 1);
    tick(); check("R8 edge3", cpu_irq, 0);
    irq_mask_sw = 1'b0;
    tick(); check("R8 release1", cpu_irq, 0);
    tick(); check("R8 release2", cpu_irq, 0);
    tick(); check("R8 release3", cpu_irq, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule